// File: doc/BRIEF.md
# Writeback-Allocating Cache Controller

This block is the control and storage core of a lower-level set-associative cache. Requests arrive one at a time from the level above: reads, writes, store-conditionals, writebacks of whole dirty blocks, and line installs that the miss path uses to place returned blocks. Each request gets a one-cycle lookup against the tag, state and data arrays. The block then reports one outcome: hit, miss, forwarded, or store-conditional failure. When a writeback misses, the block makes room for the block in this cache rather than sending it further down. It picks a victim way, queues the victim's data into an internal write-buffer queue if that victim is dirty, and stores the incoming block as a dirty line. A small table of outstanding miss entries is provided on input pins. If a valid victim's rebuilt address matches any live entry, that line is treated as unreplaceable. The allocation is then abandoned and the writeback is reported as forwarded, with the cache left untouched.

The controller is a three-state machine. S_IDLE raises `req_ready`. The accept transition (S_IDLE to S_LOOKUP) registers a request. S_LOOKUP decides the outcome in one cycle, and one of two transitions leaves it. The finish transition (S_LOOKUP to S_IDLE) commits the array update and pulses `rsp_valid`. The block transition (S_LOOKUP to S_STALL) is taken when a dirty victim must be queued and the write-buffer queue is full. S_STALL re-evaluates every cycle. Its drain transition (S_STALL to S_IDLE) completes the request once a queue slot is free. While no slot is free, the hold transition (S_STALL to S_STALL) is taken.

Top module: `wballoc_cache`

## Requirements
- R1: After reset every line is invalid and the write-buffer queue is empty: `req_ready` is 1, `rsp_valid` is 0 and `wbq_valid` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1, and `req_ready` is 1 only when no request is in progress. Unless stalled, `rsp_valid` is high for exactly the one cycle following that edge. After the response, `req_ready` returns to 1.
- R3: Address bits [SET_W-1:0] select the set and the remaining upper bits form the tag. `req_cmd` codes are: 0 read, 1 write, 2 store-conditional, 3 writeback, 4 install read-only, 5 install writable. `rsp_kind` codes are: 0 hit, 1 miss, 2 forwarded, 3 store-conditional failed. A read hits on any valid matching line and returns that line's data on `rsp_data`. A write or store-conditional hits only on a writable matching line; it stores `req_data` and marks the line dirty. `rsp_data` is 0 for every response other than a read hit.
- R4: A write or store-conditional that finds a matching line that is not writable reports miss and leaves the line's data unchanged.
- R5: A writeback that matches a read-only line copies its data in and marks the line dirty. It reports hit and leaves the line read-only, so a following write still misses.
- R6: A writeback with no matching line allocates a line that is valid, dirty and read-only, holding the writeback data, and reports hit.
- R7: The victim is the lowest-numbered invalid way of the set. If every way is valid, the set's round-robin pointer (reset 0) names the victim. The pointer advances by one, wrapping, each time a valid line is replaced.
- R8: A dirty victim is pushed into the write-buffer queue as its rebuilt address {tag, set} with its data, before the new tag is written. A clean victim is dropped. Queued victims leave on `wbq_addr`/`wbq_data` in the order they were pushed.
- R9: When the victim is valid and its rebuilt address equals the address of an outstanding entry whose valid bit is set, the writeback reports forwarded and no line changes. Entries that match only an invalid victim way, or only a line that is not the victim, do not block.
- R10: A store-conditional with no matching line reports code 3 at once and allocates nothing.
- R11: If a dirty victim must be queued while the queue is full, `req_ready` and `rsp_valid` stay 0 until a slot frees. The request then completes normally.
- R12: An install that matches a line overwrites its data and sets its writable bit from the command, keeping the dirty bit. Without a match, it allocates a clean line through the same victim rule; a blocked victim makes it report forwarded with no change.
- R13: While `wbq_valid` is 1 and `wbq_ready` is 0, the queue head on `wbq_addr`/`wbq_data` holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_cmd | input | 3 | Request command code |
| req_addr | input | LINE_AW | Block address |
| req_data | input | DATA_W | Full-block data for write, writeback, install |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_kind | output | 2 | Outcome code |
| rsp_data | output | DATA_W | Line data on read hit, else 0 |
| pend_valid | input | PEND_N | Outstanding miss entry valid bits |
| pend_addr | input | PEND_N*LINE_AW | Outstanding miss entry addresses, entry i at bits [i*LINE_AW +: LINE_AW] |
| wbq_valid | output | 1 | Write-buffer queue has a victim |
| wbq_ready | input | 1 | Downstream takes the queue head |
| wbq_addr | output | LINE_AW | Victim block address |
| wbq_data | output | DATA_W | Victim block data |

## Verification
Two conditions take the most setup from the ports. The first is a writeback whose victim is pinned by an outstanding entry: a set must be filled with valid lines, the round-robin pointer brought to a known way, and the entry table pointed at exactly that way's address. The stimulus installs lines through the install commands and tracks the pointer by counting replacements. It then shows that an entry naming the other way, or naming the reset-state tag of an invalid way, does not block. The second is the full-queue stall. The bench holds `wbq_ready` low while consecutive writebacks evict dirty lines until the queue is full. It watches that the next request stays unanswered and checks the order of the victims that drain once `wbq_ready` rises.

// File: rtl/wballoc_pkg.sv
package wballoc_pkg;

    typedef enum logic [2:0] {
        CMD_READ    = 3'd0,
        CMD_WRITE   = 3'd1,
        CMD_SCOND   = 3'd2,
        CMD_WBACK   = 3'd3,
        CMD_FILL_RO = 3'd4,
        CMD_FILL_RW = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        RSP_HIT    = 2'd0,
        RSP_MISS   = 2'd1,
        RSP_FWD    = 2'd2,
        RSP_SCFAIL = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LOOKUP = 2'd1,
        S_STALL  = 2'd2
    } fsm_e;

    typedef struct packed {
        logic valid;
        logic writable;
        logic dirty;
    } line_st_t;

endpackage

// File: rtl/wballoc_arrays.sv
module wballoc_arrays
    import wballoc_pkg::*;
#(
    parameter int SET_W  = 2,
    parameter int WAYS   = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    localparam int SETS  = 1 << SET_W,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [SET_W-1:0]               rd_set,
    output line_st_t [WAYS-1:0]            rd_state,
    output logic [WAYS-1:0][TAG_W-1:0]     rd_tag,
    output logic [WAYS-1:0][DATA_W-1:0]    rd_data,
    output logic [WAY_W-1:0]               rd_rr,
    input  logic                           wr_en,
    input  logic [WAY_W-1:0]               wr_way,
    input  line_st_t                       wr_state,
    input  logic [TAG_W-1:0]               wr_tag,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic                           rr_adv
);

    line_st_t          st_q   [SETS][WAYS];
    logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
    logic [DATA_W-1:0] data_q [SETS][WAYS];
    logic [WAY_W-1:0]  rr_q   [SETS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                rr_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    st_q[s][w]   <= '0;
                    tag_q[s][w]  <= '0;
                    data_q[s][w] <= '0;
                end
            end
        end else begin
            if (wr_en) begin
                st_q[rd_set][wr_way]   <= wr_state;
                tag_q[rd_set][wr_way]  <= wr_tag;
                data_q[rd_set][wr_way] <= wr_data;
            end
            if (rr_adv) begin
                rr_q[rd_set] <= (rr_q[rd_set] == WAY_W'(WAYS - 1)) ? '0 : rr_q[rd_set] + 1'b1;
            end
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_state[w] = st_q[rd_set][w];
        assign rd_tag[w]   = tag_q[rd_set][w];
        assign rd_data[w]  = data_q[rd_set][w];
    end

    assign rd_rr = rr_q[rd_set];

endmodule

// File: rtl/wballoc_waysel.sv
module wballoc_waysel
    import wballoc_pkg::*;
#(
    parameter int LINE_AW = 8,
    parameter int SET_W   = 2,
    parameter int WAYS    = 2,
    parameter int PEND_N  = 2,
    localparam int TAG_W  = LINE_AW - SET_W,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  line_st_t [WAYS-1:0]         rd_state,
    input  logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    input  logic [TAG_W-1:0]            look_tag,
    input  logic [SET_W-1:0]            look_set,
    input  logic [WAY_W-1:0]            rr_ptr,
    input  logic [PEND_N-1:0]           pend_valid,
    input  logic [PEND_N*LINE_AW-1:0]   pend_addr,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way,
    output logic [WAY_W-1:0]            vic_way,
    output logic                        vic_valid,
    output logic                        vic_dirty,
    output logic [LINE_AW-1:0]          vic_addr,
    output logic                        vic_blocked
);

    logic [WAYS-1:0]   way_match;
    logic [PEND_N-1:0] pend_hit;
    logic              free_found;
    logic [WAY_W-1:0]  free_way;
    line_st_t          vic_st;

    for (genvar w = 0; w < WAYS; w++) begin : g_match
        assign way_match[w] = rd_state[w].valid && (rd_tag[w] == look_tag);
    end

    // scan downward so the lowest index wins for both searches
    always_comb begin
        hit_way    = '0;
        free_found = 1'b0;
        free_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_match[w]) begin
                hit_way = WAY_W'(w);
            end
            if (!rd_state[w].valid) begin
                free_found = 1'b1;
                free_way   = WAY_W'(w);
            end
        end
    end

    assign hit       = |way_match;
    assign vic_way   = free_found ? free_way : rr_ptr;
    assign vic_st    = rd_state[vic_way];
    assign vic_valid = vic_st.valid;
    assign vic_dirty = vic_st.dirty;
    assign vic_addr  = {rd_tag[vic_way], look_set};

    for (genvar p = 0; p < PEND_N; p++) begin : g_pend
        assign pend_hit[p] = pend_valid[p] && (pend_addr[p*LINE_AW +: LINE_AW] == vic_addr);
    end

    assign vic_blocked = vic_valid && (|pend_hit);

endmodule

// File: rtl/wballoc_wbq.sv
module wballoc_wbq #(
    parameter int W     = 24,
    parameter int DEPTH = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         full,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             pop;
    logic             put;

    assign pop       = out_valid && out_ready;
    assign put       = push && !full;
    assign full      = (count_q == CNT_W'(DEPTH));
    assign out_valid = (count_q != '0);
    assign out_data  = mem_q[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (put) begin
            mem_q[wr_ptr_q] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (put) begin
                wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            end
            if (pop) begin
                rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
            end
            unique case ({put, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

endmodule

// File: rtl/wballoc_cache.sv
module wballoc_cache
    import wballoc_pkg::*;
#(
    parameter int LINE_AW   = 8,
    parameter int SET_W     = 2,
    parameter int WAYS      = 2,
    parameter int DATA_W    = 16,
    parameter int PEND_N    = 2,
    parameter int WBQ_DEPTH = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [2:0]                req_cmd,
    input  logic [LINE_AW-1:0]        req_addr,
    input  logic [DATA_W-1:0]         req_data,
    output logic                      rsp_valid,
    output logic [1:0]                rsp_kind,
    output logic [DATA_W-1:0]         rsp_data,
    input  logic [PEND_N-1:0]         pend_valid,
    input  logic [PEND_N*LINE_AW-1:0] pend_addr,
    output logic                      wbq_valid,
    input  logic                      wbq_ready,
    output logic [LINE_AW-1:0]        wbq_addr,
    output logic [DATA_W-1:0]         wbq_data
);

    localparam int TAG_W = LINE_AW - SET_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int WBQ_W = LINE_AW + DATA_W;

    fsm_e                       state_q, state_d;
    cmd_e                       cmd_q;
    logic [LINE_AW-1:0]         addr_q;
    logic [DATA_W-1:0]          data_q;

    logic [SET_W-1:0]           look_set;
    logic [TAG_W-1:0]           look_tag;
    line_st_t [WAYS-1:0]        rd_state;
    logic [WAYS-1:0][TAG_W-1:0] rd_tag;
    logic [WAYS-1:0][DATA_W-1:0] rd_data;
    logic [WAY_W-1:0]           rd_rr;

    logic                       hit;
    logic [WAY_W-1:0]           hit_way;
    logic [WAY_W-1:0]           vic_way;
    logic                       vic_valid;
    logic                       vic_dirty;
    logic [LINE_AW-1:0]         vic_addr;
    logic                       vic_blocked;

    line_st_t                   hit_st;
    logic                       need_excl;
    logic                       perm_ok;
    rsp_e                       act_kind;
    logic [DATA_W-1:0]          act_rdata;
    logic                       upd;
    logic [WAY_W-1:0]           upd_way;
    line_st_t                   upd_st;
    logic [DATA_W-1:0]          upd_data;
    logic                       alloc;

    logic                       busy;
    logic                       need_push;
    logic                       wbq_full;
    logic                       stall_now;
    logic                       commit;
    logic [WBQ_W-1:0]           wbq_head;

    assign look_set = addr_q[SET_W-1:0];
    assign look_tag = addr_q[LINE_AW-1:SET_W];

    wballoc_arrays #(
        .SET_W (SET_W),
        .WAYS  (WAYS),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_arrays (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_set  (look_set),
        .rd_state(rd_state),
        .rd_tag  (rd_tag),
        .rd_data (rd_data),
        .rd_rr   (rd_rr),
        .wr_en   (commit && upd),
        .wr_way  (upd_way),
        .wr_state(upd_st),
        .wr_tag  (look_tag),
        .wr_data (upd_data),
        .rr_adv  (commit && alloc && vic_valid)
    );

    wballoc_waysel #(
        .LINE_AW(LINE_AW),
        .SET_W  (SET_W),
        .WAYS   (WAYS),
        .PEND_N (PEND_N)
    ) u_waysel (
        .rd_state   (rd_state),
        .rd_tag     (rd_tag),
        .look_tag   (look_tag),
        .look_set   (look_set),
        .rr_ptr     (rd_rr),
        .pend_valid (pend_valid),
        .pend_addr  (pend_addr),
        .hit        (hit),
        .hit_way    (hit_way),
        .vic_way    (vic_way),
        .vic_valid  (vic_valid),
        .vic_dirty  (vic_dirty),
        .vic_addr   (vic_addr),
        .vic_blocked(vic_blocked)
    );

    wballoc_wbq #(
        .W    (WBQ_W),
        .DEPTH(WBQ_DEPTH)
    ) u_wbq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (commit && need_push),
        .push_data({vic_addr, rd_data[vic_way]}),
        .full     (wbq_full),
        .out_valid(wbq_valid),
        .out_ready(wbq_ready),
        .out_data (wbq_head)
    );

    assign wbq_addr = wbq_head[WBQ_W-1:DATA_W];
    assign wbq_data = wbq_head[DATA_W-1:0];

    // outcome of the request held in addr_q/cmd_q/data_q
    always_comb begin
        hit_st    = rd_state[hit_way];
        need_excl = (cmd_q == CMD_WRITE) || (cmd_q == CMD_SCOND);
        perm_ok   = hit && (need_excl ? hit_st.writable : hit_st.valid);
        act_kind  = RSP_MISS;
        act_rdata = '0;
        upd       = 1'b0;
        upd_way   = hit_way;
        upd_st    = hit_st;
        upd_data  = data_q;
        alloc     = 1'b0;
        unique case (cmd_q)
            CMD_READ: begin
                if (perm_ok) begin
                    act_kind  = RSP_HIT;
                    act_rdata = rd_data[hit_way];
                end
            end
            CMD_WRITE, CMD_SCOND: begin
                if (perm_ok) begin
                    act_kind     = RSP_HIT;
                    upd          = 1'b1;
                    upd_st.dirty = 1'b1;
                end else if ((cmd_q == CMD_SCOND) && !hit) begin
                    act_kind = RSP_SCFAIL;
                end
            end
            CMD_WBACK: begin
                if (hit) begin
                    act_kind     = RSP_HIT;
                    upd          = 1'b1;
                    upd_st.dirty = 1'b1;
                end else if (vic_blocked) begin
                    act_kind = RSP_FWD;
                end else begin
                    act_kind = RSP_HIT;
                    upd      = 1'b1;
                    alloc    = 1'b1;
                    upd_way  = vic_way;
                    upd_st   = '{valid: 1'b1, writable: 1'b0, dirty: 1'b1};
                end
            end
            CMD_FILL_RO, CMD_FILL_RW: begin
                if (hit) begin
                    act_kind        = RSP_HIT;
                    upd             = 1'b1;
                    upd_st.writable = (cmd_q == CMD_FILL_RW);
                end else if (vic_blocked) begin
                    act_kind = RSP_FWD;
                end else begin
                    act_kind = RSP_HIT;
                    upd      = 1'b1;
                    alloc    = 1'b1;
                    upd_way  = vic_way;
                    upd_st   = '{valid: 1'b1, writable: (cmd_q == CMD_FILL_RW), dirty: 1'b0};
                end
            end
            default: begin
                act_kind = RSP_MISS;
            end
        endcase
    end

    assign busy      = (state_q != S_IDLE);
    assign need_push = alloc && vic_valid && vic_dirty;
    assign stall_now = busy && need_push && wbq_full;
    assign commit    = busy && !stall_now;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   state_d = req_valid ? S_LOOKUP : S_IDLE;
            S_LOOKUP: state_d = stall_now ? S_STALL : S_IDLE;
            S_STALL:  state_d = stall_now ? S_STALL : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request capture on the accept transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_READ;
            addr_q <= '0;
            data_q <= '0;
        end else if ((state_q == S_IDLE) && req_valid) begin
            cmd_q  <= cmd_e'(req_cmd);
            addr_q <= req_addr;
            data_q <= req_data;
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == S_IDLE);
        rsp_valid = commit;
        rsp_kind  = act_kind;
        rsp_data  = busy ? act_rdata : '0;
    end

endmodule

// File: rtl/wballoc_cache_chk.sv
module wballoc_cache_chk #(
    parameter int LINE_AW = 8,
    parameter int DATA_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic [1:0]         rsp_kind,
    input logic [DATA_W-1:0]  rsp_data,
    input logic               wbq_valid,
    input logic               wbq_ready,
    input logic [LINE_AW-1:0] wbq_addr,
    input logic [DATA_W-1:0]  wbq_data
);

    // R2
    accept_closes_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R3
    quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_kind != 2'd0)) |-> (rsp_data == '0));

    // R13
    wbq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wbq_valid && !wbq_ready) |=> (wbq_valid && $stable(wbq_addr) && $stable(wbq_data)));

endmodule

bind wballoc_cache wballoc_cache_chk #(
    .LINE_AW(LINE_AW),
    .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/wballoc_cache_bench.sv
`timescale 1ns/1ps
module wballoc_cache_bench;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int PN = 2;
    localparam int NV = 29;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_cmd = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_kind;
    logic [DW-1:0] rsp_data;
    logic [PN-1:0] pend_valid = '0;
    logic [PN*AW-1:0] pend_addr = '0;
    logic          wbq_valid;
    logic          wbq_ready = 1'b1;
    logic [AW-1:0] wbq_addr;
    logic [DW-1:0] wbq_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [AW-1:0] pop_addr [16];
    logic [DW-1:0] pop_data [16];
    int            pop_n = 0;

    always #2 clk = ~clk;

    wballoc_cache u_wballoc_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
        .pend_valid(pend_valid), .pend_addr(pend_addr),
        .wbq_valid(wbq_valid), .wbq_ready(wbq_ready),
        .wbq_addr(wbq_addr), .wbq_data(wbq_data)
    );

    // record queue pops: taken at the next rising edge
    always @(negedge clk) begin
        if (rst_n && wbq_valid && wbq_ready && pop_n < 16) begin
            pop_addr[pop_n] = wbq_addr;
            pop_data[pop_n] = wbq_data;
            pop_n++;
        end
    end

    // cmd, addr, data, expected kind, expected rsp_data
    localparam logic [44:0] VEC [NV] = '{
        {3'd0, 8'h01, 16'h0000, 2'd1, 16'h0000},
        {3'd2, 8'h01, 16'hAAAA, 2'd3, 16'h0000},
        {3'd3, 8'h01, 16'h1111, 2'd0, 16'h0000},
        {3'd0, 8'h01, 16'h0000, 2'd0, 16'h1111},
        {3'd1, 8'h01, 16'h2222, 2'd1, 16'h0000},
        {3'd0, 8'h01, 16'h0000, 2'd0, 16'h1111},
        {3'd3, 8'h01, 16'h3333, 2'd0, 16'h0000},
        {3'd0, 8'h01, 16'h0000, 2'd0, 16'h3333},
        {3'd1, 8'h01, 16'h4444, 2'd1, 16'h0000},
        {3'd5, 8'h05, 16'h5555, 2'd0, 16'h0000},
        {3'd1, 8'h05, 16'h6666, 2'd0, 16'h0000},
        {3'd2, 8'h05, 16'h7777, 2'd0, 16'h0000},
        {3'd0, 8'h05, 16'h0000, 2'd0, 16'h7777},
        {3'd2, 8'h09, 16'h9090, 2'd3, 16'h0000},
        {3'd0, 8'h09, 16'h0000, 2'd1, 16'h0000},
        {3'd3, 8'h09, 16'h9999, 2'd0, 16'h0000},
        {3'd0, 8'h01, 16'h0000, 2'd1, 16'h0000},
        {3'd0, 8'h05, 16'h0000, 2'd0, 16'h7777},
        {3'd3, 8'h0D, 16'hDDDD, 2'd0, 16'h0000},
        {3'd0, 8'h05, 16'h0000, 2'd1, 16'h0000},
        {3'd0, 8'h09, 16'h0000, 2'd0, 16'h9999},
        {3'd4, 8'h02, 16'h0202, 2'd0, 16'h0000},
        {3'd1, 8'h02, 16'h2020, 2'd1, 16'h0000},
        {3'd4, 8'h06, 16'h0606, 2'd0, 16'h0000},
        {3'd3, 8'h0A, 16'h0A0A, 2'd0, 16'h0000},
        {3'd0, 8'h02, 16'h0000, 2'd1, 16'h0000},
        {3'd0, 8'h0A, 16'h0000, 2'd0, 16'h0A0A},
        {3'd4, 8'h0A, 16'hBBBB, 2'd0, 16'h0000},
        {3'd0, 8'h0A, 16'h0000, 2'd0, 16'hBBBB}
    };

    function automatic string vec_req(int i);
        case (i)
            0:              return "R3";
            1, 13, 14:      return "R10";
            2, 3:           return "R6";
            4, 5:           return "R4";
            6, 7, 8:        return "R5";
            10, 11, 12:     return "R3";
            15, 16, 17, 18, 19, 20: return "R7";
            24, 25, 26:     return "R8";
            default:        return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_cmd   = c;
        req_addr  = a;
        req_data  = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_rsp(output logic [1:0] k, output logic [DW-1:0] rd);
        while (!rsp_valid) @(negedge clk);
        k  = rsp_kind;
        rd = rsp_data;
    endtask

    task automatic do_req(input string tag, input logic [2:0] c, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic [1:0] ek, input logic [DW-1:0] erd);
        logic [1:0]    k;
        logic [DW-1:0] rd;
        issue(c, a, d);
        wait_rsp(k, rd);
        check(tag, $sformatf("kind cmd=%0d addr=%0h", c, a), 32'(k), 32'(ek));
        check(tag, $sformatf("data cmd=%0d addr=%0h", c, a), 32'(rd), 32'(erd));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [1:0]    k;
        logic [DW-1:0] rd;
        int            base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "req_ready", 32'(req_ready), 32'd1);
        check("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1", "wbq_valid", 32'(wbq_valid), 32'd0);

        // R2 response strobe lands one cycle after acceptance
        @(negedge clk);
        req_valid = 1'b1; req_cmd = 3'd0; req_addr = 8'h03; req_data = '0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2", "rsp_valid after accept", 32'(rsp_valid), 32'd1);
        check("R2", "ready low in lookup", 32'(req_ready), 32'd0);
        @(negedge clk);
        check("R2", "rsp_valid dropped", 32'(rsp_valid), 32'd0);
        check("R2", "ready back", 32'(req_ready), 32'd1);

        for (int i = 0; i < NV; i++) begin
            do_req(vec_req(i), VEC[i][44:42], VEC[i][41:34], VEC[i][33:18],
                   VEC[i][17:16], VEC[i][15:0]);
        end
        repeat (2) @(negedge clk);
        // R8 dirty victims queued in order, clean victim dropped
        check("R8", "pop count", 32'(pop_n), 32'd2);
        check("R8", "pop0 addr", 32'(pop_addr[0]), 32'h01);
        check("R8", "pop0 data", 32'(pop_data[0]), 32'h3333);
        check("R8", "pop1 addr", 32'(pop_addr[1]), 32'h05);
        check("R8", "pop1 data", 32'(pop_data[1]), 32'h7777);

        // R9 pinned victim in set 3
        do_req("R12", 3'd4, 8'h03, 16'h3030, 2'd0, 16'h0);
        do_req("R12", 3'd4, 8'h07, 16'h7070, 2'd0, 16'h0);
        pend_valid = 2'b01; pend_addr = {8'h00, 8'h03};
        do_req("R9", 3'd3, 8'h0B, 16'hB0B0, 2'd2, 16'h0);
        do_req("R9", 3'd0, 8'h03, 16'h0, 2'd0, 16'h3030);
        do_req("R9", 3'd0, 8'h0B, 16'h0, 2'd1, 16'h0);
        pend_addr = {8'h00, 8'h07};
        do_req("R9", 3'd3, 8'h0B, 16'hB0B0, 2'd0, 16'h0);
        do_req("R9", 3'd0, 8'h03, 16'h0, 2'd1, 16'h0);
        do_req("R9", 3'd0, 8'h07, 16'h0, 2'd0, 16'h7070);
        // rr of set 3 now names way 1 (line 0x07), still pinned
        do_req("R12", 3'd5, 8'h0F, 16'hF0F0, 2'd2, 16'h0);
        do_req("R12", 3'd0, 8'h07, 16'h0, 2'd0, 16'h7070);
        // entry matching only the reset tag of an invalid way
        pend_valid = 2'b10; pend_addr = {8'h00, 8'h00};
        do_req("R9", 3'd3, 8'h04, 16'h4040, 2'd0, 16'h0);
        do_req("R9", 3'd0, 8'h04, 16'h0, 2'd0, 16'h4040);
        pend_valid = 2'b00;
        check("R8", "no push for clean victim", 32'(pop_n), 32'd2);

        // R11 full queue stalls the request
        base = pop_n;
        wbq_ready = 1'b0;
        do_req("R11", 3'd3, 8'h08, 16'h0808, 2'd0, 16'h0);
        do_req("R11", 3'd3, 8'h0C, 16'h0C0C, 2'd0, 16'h0);
        do_req("R11", 3'd3, 8'h10, 16'h1010, 2'd0, 16'h0);
        check("R13", "head addr held", 32'(wbq_addr), 32'h04);
        check("R13", "head data held", 32'(wbq_data), 32'h4040);
        issue(3'd3, 8'h14, 16'h1414);
        for (int c = 0; c < 4; c++) begin
            check("R11", "no response while full", 32'(rsp_valid), 32'd0);
            check("R11", "ready low while full", 32'(req_ready), 32'd0);
            @(negedge clk);
        end
        wbq_ready = 1'b1;
        wait_rsp(k, rd);
        check("R11", "stalled writeback result", 32'(k), 32'd0);
        repeat (6) @(negedge clk);
        check("R8", "stall pops", 32'(pop_n - base), 32'd3);
        check("R8", "stall pop0", 32'({pop_addr[base], pop_data[base]}), 32'h04_4040);
        check("R8", "stall pop1", 32'({pop_addr[base+1], pop_data[base+1]}), 32'h08_0808);
        check("R8", "stall pop2", 32'({pop_addr[base+2], pop_data[base+2]}), 32'h0C_0C0C);
        do_req("R7", 3'd0, 8'h0C, 16'h0, 2'd1, 16'h0);
        do_req("R11", 3'd0, 8'h14, 16'h0, 2'd0, 16'h1414);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule